// File: doc/BRIEF.md
# Broadcast-and-Select Output Port

This block is one output channel of a broadcast-and-select crossbar. All input lanes (64 by default, seen as an 8×8 set numbered 0–63) reach every output port at once. There is no central fabric and no routing table. Each lane carries one packet per slot, with a valid flag. The packet is a single fixed-length word: a destination field in its upper bits and a payload below it. The port keeps only the packets whose destination field equals its own index, which is fixed by a parameter. All other packets pass it by.

When more matching packets arrive than the output can carry, the port resolves the contention itself. A round-robin arbiter takes up to a set number of them per slot. Packets that cannot leave at once go into a local FIFO beside the output, and packets already queued always leave first. A matching lane that is not taken in a slot sees its stall flag raised and must hold its packet, so nothing is overwritten or dropped. A parameter adds one or two overflow outputs, so that extra packets can leave in the same slot. A second parameter selects whether the destination field is removed from the word sent out or kept in it.

Top module: `bsp_output_port`

## Requirements
- R1: Lane `i` occupies bits `[i*WORD_W +: WORD_W]` of `in_word`, where `WORD_W = HDR_W + DATA_W` and `HDR_W = clog2(N_IN)`. The destination field sits in the top `HDR_W` bits of the lane word and the payload in the low `DATA_W` bits. A valid packet whose destination equals `PORT_ID` is accepted.
- R2: A valid packet with any other destination is ignored. It raises no stall and produces no output.
- R3: When the buffer is empty, an accepted packet appears on output slot 0 with `out_valid` high on the clock edge that ends the slot in which it was accepted.
- R4: Per slot the arbiter grants up to `GRANTS` matching lanes. It scans upward from a pointer, wrapping from lane `N_IN-1` to lane 0. Afterwards the pointer moves to one past the last granted lane. After reset the pointer is 0.
- R5: Packets held in the buffer are sent before packets arriving in the current slot. Packets leave in the order in which they were accepted, and lanes granted in the same slot leave in scan order.
- R6: A valid matching lane that is not granted in a slot sees `in_stall` high during that slot and must hold its packet. The buffer never holds more than `DEPTH` packets, and no accepted packet is lost.
- R7: With `HDR_MODE = HDR_STRIP` an output slot carries only the payload (`DATA_W` bits). With `HDR_KEEP` it carries the whole lane word, destination field included.
- R8: There are `1 + EXTRA_OUTS` output slots, packed into `out_data` at `[j*OUT_W +: OUT_W]`. They are filled from slot 0 upward, so slot `j` is valid only if slot `j-1` is valid.
- R9: While `rst` is high, and in the first cycle after it, every `out_valid` bit is 0 and the buffer is empty. During reset no packet is accepted.
- R10: Between two slots, the buffer occupancy changes by exactly the number of packets accepted minus the number of output slots driven valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_IN | Per-lane packet-present flag |
| in_word | input | N_IN*WORD_W | All lane words, lane `i` at `[i*WORD_W +: WORD_W]` |
| in_stall | output | N_IN | Per-lane hold request for matching packets not taken this slot |
| out_valid | output | 1+EXTRA_OUTS | Per-slot output valid, registered |
| out_data | output | (1+EXTRA_OUTS)*OUT_W | Output slot words, registered |

## Verification
A single matching lane, shown once alone and once among lanes bound elsewhere, separates correct destination decoding from a port that takes every valid lane. Three simultaneous matching lanes on low indices, and a later set that crosses lane 63, show whether the arbiter grants in scan order, wraps around, and drains the buffer ahead of a newcomer. A burst of twelve matching lanes fills the four-entry buffer and tells a port that stalls correctly from one that overwrites or drops packets. A second instance with one overflow output and the header kept shows two packets leaving in one slot, each with its destination field intact.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    // What the output slot carries: payload only, or the full lane word.
    typedef enum logic {
        HDR_STRIP = 1'b0,
        HDR_KEEP  = 1'b1
    } hdr_mode_e;

    // Circular index arithmetic shared by the arbiter and the buffer.
    function automatic int unsigned wrap_add(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned m);
        return (a + b) % m;
    endfunction

    function automatic int unsigned min_u(input int unsigned a,
                                          input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/bsp_hdr_match.sv
module bsp_hdr_match #(
    parameter int N_IN    = 64,
    parameter int DATA_W  = 16,
    parameter int PORT_ID = 5,
    localparam int HDR_W  = $clog2(N_IN),
    localparam int WORD_W = HDR_W + DATA_W
) (
    input  logic [N_IN-1:0]        in_valid,
    input  logic [N_IN*WORD_W-1:0] in_word,
    output logic [N_IN-1:0]        match
);
    // One comparator per lane against the static port index.
    for (genvar i = 0; i < N_IN; i++) begin : g_lane
        assign match[i] = in_valid[i] &&
            (in_word[i*WORD_W + DATA_W +: HDR_W] == HDR_W'(PORT_ID));
    end
endmodule

// File: rtl/bsp_rr_arbiter.sv
module bsp_rr_arbiter
    import bsp_pkg::*;
#(
    parameter int N_IN   = 64,
    parameter int GRANTS = 2,
    localparam int IW    = $clog2(N_IN),
    localparam int AW    = $clog2(GRANTS + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] req,
    input  logic [AW-1:0]   allow,
    output logic            grant_vld [GRANTS],
    output logic [IW-1:0]   grant_idx [GRANTS],
    output logic [N_IN-1:0] grant_mask
);
    logic [IW-1:0] ptr_q;
    logic [IW-1:0] ptr_n;

    // Each grant stage scans from the pointer, skipping lanes already taken.
    always_comb begin
        int unsigned idx;
        grant_mask = '0;
        idx = 0;
        for (int k = 0; k < GRANTS; k++) begin
            grant_vld[k] = 1'b0;
            grant_idx[k] = '0;
            if (k < int'(allow)) begin
                for (int j = 0; j < N_IN; j++) begin
                    idx = wrap_add(int'(ptr_q), j, N_IN);
                    if (!grant_vld[k] && req[idx] && !grant_mask[idx]) begin
                        grant_vld[k]    = 1'b1;
                        grant_idx[k]    = IW'(idx);
                        grant_mask[idx] = 1'b1;
                    end
                end
            end
        end
    end

    // Pointer moves one past the last lane granted this slot.
    always_comb begin
        ptr_n = ptr_q;
        for (int k = 0; k < GRANTS; k++) begin
            if (grant_vld[k]) begin
                ptr_n = IW'(wrap_add(int'(grant_idx[k]), 1, N_IN));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_n;
        end
    end
endmodule

// File: rtl/bsp_slot_fifo.sv
module bsp_slot_fifo
    import bsp_pkg::*;
#(
    parameter int WORD_W  = 22,
    parameter int DEPTH   = 4,
    parameter int N_WR    = 2,
    parameter int N_RD    = 1,
    localparam int PW     = $clog2(DEPTH),
    localparam int FW     = $clog2(DEPTH + 1),
    localparam int WNW    = $clog2(N_WR + 1),
    localparam int RNW    = $clog2(N_RD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WNW-1:0]    wr_num,
    input  logic [WORD_W-1:0] wr_data [N_WR],
    input  logic [RNW-1:0]    rd_num,
    output logic [WORD_W-1:0] head [N_RD],
    output logic [FW-1:0]     fill
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [PW-1:0]     rd_ptr;
    logic [PW-1:0]     wr_ptr;

    // The first N_RD queued entries, oldest at index 0.
    for (genvar j = 0; j < N_RD; j++) begin : g_head
        assign head[j] = mem[wrap_add(int'(rd_ptr), j, DEPTH)];
    end

    // Several writes per slot land in consecutive entries.
    always_ff @(posedge clk) begin
        for (int k = 0; k < N_WR; k++) begin
            if (k < int'(wr_num)) begin
                mem[wrap_add(int'(wr_ptr), k, DEPTH)] <= wr_data[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else begin
            wr_ptr <= PW'(wrap_add(int'(wr_ptr), int'(wr_num), DEPTH));
            rd_ptr <= PW'(wrap_add(int'(rd_ptr), int'(rd_num), DEPTH));
            fill   <= FW'(int'(fill) + int'(wr_num) - int'(rd_num));
        end
    end
endmodule

// File: rtl/bsp_output_port.sv
module bsp_output_port
    import bsp_pkg::*;
#(
    parameter int        N_IN       = 64,
    parameter int        DATA_W     = 16,
    parameter int        PORT_ID    = 5,
    parameter int        DEPTH      = 4,
    parameter int        GRANTS     = 2,
    parameter int        EXTRA_OUTS = 0,
    parameter hdr_mode_e HDR_MODE   = HDR_STRIP,
    localparam int HDR_W  = $clog2(N_IN),
    localparam int WORD_W = HDR_W + DATA_W,
    localparam int N_OUT  = 1 + EXTRA_OUTS,
    localparam int OUT_W  = (HDR_MODE == HDR_STRIP) ? DATA_W : WORD_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_IN-1:0]        in_valid,
    input  logic [N_IN*WORD_W-1:0] in_word,
    output logic [N_IN-1:0]        in_stall,
    output logic [N_OUT-1:0]       out_valid,
    output logic [N_OUT*OUT_W-1:0] out_data
);
    localparam int IW  = $clog2(N_IN);
    localparam int AW  = $clog2(GRANTS + 1);
    localparam int RNW = $clog2(N_OUT + 1);
    localparam int FW  = $clog2(DEPTH + 1);

    logic [N_IN-1:0]   match;
    logic [WORD_W-1:0] lane_word [N_IN];
    logic [AW-1:0]     allow;
    logic              grant_vld [GRANTS];
    logic [IW-1:0]     grant_idx [GRANTS];
    logic [N_IN-1:0]   grant_mask;
    logic [AW-1:0]     wr_num;
    logic [WORD_W-1:0] wr_data [GRANTS];
    logic [RNW-1:0]    rd_num;
    logic [WORD_W-1:0] head [N_OUT];
    logic [FW-1:0]     fill;
    logic              ov_n [N_OUT];
    logic [OUT_W-1:0]  od_n [N_OUT];
    logic              ov_q [N_OUT];
    logic [OUT_W-1:0]  od_q [N_OUT];

    for (genvar i = 0; i < N_IN; i++) begin : g_unpack
        assign lane_word[i] = in_word[i*WORD_W +: WORD_W];
    end

    bsp_hdr_match #(
        .N_IN    (N_IN),
        .DATA_W  (DATA_W),
        .PORT_ID (PORT_ID)
    ) u_match (
        .in_valid (in_valid),
        .in_word  (in_word),
        .match    (match)
    );

    bsp_rr_arbiter #(
        .N_IN   (N_IN),
        .GRANTS (GRANTS)
    ) u_arb (
        .clk        (clk),
        .rst        (rst),
        .req        (match),
        .allow      (allow),
        .grant_vld  (grant_vld),
        .grant_idx  (grant_idx),
        .grant_mask (grant_mask)
    );

    bsp_slot_fifo #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH),
        .N_WR   (GRANTS),
        .N_RD   (N_OUT)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_num  (wr_num),
        .wr_data (wr_data),
        .rd_num  (rd_num),
        .head    (head),
        .fill    (fill)
    );

    // Slot planning: queued packets take output slots first, new grants
    // fill what remains, and the rest of the grants go into the buffer.
    // Grants are limited to what the output and the free space can absorb.
    always_comb begin
        int unsigned n_rd;
        int unsigned room;
        int unsigned space;
        int unsigned n_gnt;
        int unsigned n_byp;
        int unsigned sel;
        n_rd  = min_u(N_OUT, int'(fill));
        room  = N_OUT - n_rd;
        space = DEPTH - int'(fill) + n_rd;
        allow = rst ? '0 : AW'(min_u(GRANTS, room + space));
        n_gnt = 0;
        for (int k = 0; k < GRANTS; k++) begin
            if (grant_vld[k]) n_gnt = n_gnt + 1;
        end
        n_byp  = min_u(n_gnt, room);
        wr_num = AW'(n_gnt - n_byp);
        rd_num = RNW'(n_rd);
        for (int k = 0; k < GRANTS; k++) begin
            sel = k + n_byp;
            wr_data[k] = (sel < GRANTS) ? lane_word[grant_idx[sel]] : '0;
        end
        // OUT_W'() keeps the payload bits in strip mode, the whole word otherwise.
        for (int j = 0; j < N_OUT; j++) begin
            ov_n[j] = 1'b0;
            od_n[j] = '0;
            if (j < n_rd) begin
                ov_n[j] = 1'b1;
                od_n[j] = OUT_W'(head[j]);
            end else if (j - n_rd < n_byp) begin
                ov_n[j] = 1'b1;
                od_n[j] = OUT_W'(lane_word[grant_idx[j - n_rd]]);
            end
        end
    end

    assign in_stall = match & ~grant_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < N_OUT; j++) begin
                ov_q[j] <= 1'b0;
                od_q[j] <= '0;
            end
        end else begin
            for (int j = 0; j < N_OUT; j++) begin
                ov_q[j] <= ov_n[j];
                od_q[j] <= od_n[j];
            end
        end
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_pack
        assign out_valid[j]              = ov_q[j];
        assign out_data[j*OUT_W +: OUT_W] = od_q[j];
    end
endmodule

// File: rtl/bsp_port_checker.sv
module bsp_port_checker #(
    parameter int N_IN    = 64,
    parameter int DATA_W  = 16,
    parameter int PORT_ID = 5,
    parameter int DEPTH   = 4,
    parameter int GRANTS  = 2,
    parameter int N_OUT   = 1,
    parameter int FW      = 3,
    localparam int HDR_W  = $clog2(N_IN),
    localparam int WORD_W = HDR_W + DATA_W
) (
    input logic                   clk,
    input logic                   rst,
    input logic [N_IN-1:0]        in_valid,
    input logic [N_IN*WORD_W-1:0] in_word,
    input logic [N_IN-1:0]        in_stall,
    input logic [N_OUT-1:0]       out_valid,
    input logic [FW-1:0]          fill
);
    logic [N_IN-1:0] hit;
    logic [N_IN-1:0] taken;

    for (genvar i = 0; i < N_IN; i++) begin : g_hit
        assign hit[i] = in_valid[i] &&
            (in_word[i*WORD_W + DATA_W +: HDR_W] == HDR_W'(PORT_ID));
    end
    assign taken = hit & ~in_stall;

    // R2: only lanes addressed to this port may ever be stalled
    a_r2_stall_only_hits: assert property (@(posedge clk) disable iff (rst)
        (in_stall & ~hit) == '0);

    // R4: never more lanes taken in a slot than the grant budget
    a_r4_grant_budget: assert property (@(posedge clk) disable iff (rst)
        $countones(taken) <= GRANTS);

    // R6: buffer occupancy bounded by its depth
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        int'(fill) <= DEPTH);

    // R9: outputs quiet on the first slot after reset
    a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_valid == '0 && fill == '0));

    // R10: every accepted packet either leaves or stays buffered
    a_r10_conserve: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> int'(fill) ==
            int'($past(fill)) + $countones($past(taken)) - $countones(out_valid));

    // R8: output slots fill from slot 0 upward
    for (genvar j = 1; j < N_OUT; j++) begin : g_slot
        a_r8_slot_prefix: assert property (@(posedge clk) disable iff (rst)
            out_valid[j] |-> out_valid[j-1]);
    end
endmodule

bind bsp_output_port bsp_port_checker #(
    .N_IN    (N_IN),
    .DATA_W  (DATA_W),
    .PORT_ID (PORT_ID),
    .DEPTH   (DEPTH),
    .GRANTS  (GRANTS),
    .N_OUT   (N_OUT),
    .FW      (FW)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_stall  (in_stall),
    .out_valid (out_valid),
    .fill      (fill)
);

// File: tb/bsp_output_port_tb.sv
module bsp_output_port_tb_top;
    import bsp_pkg::*;

    localparam int NL = 64;
    localparam int DW = 16;
    localparam int WW = 22;
    localparam int ME = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NL-1:0]   vld = '0;
    logic [NL*WW-1:0] wrd = '0;
    logic [NL-1:0]   stall_i;
    logic [0:0]      ov_i;
    logic [DW-1:0]   od_i;
    logic [NL-1:0]   stall_x;
    logic [1:0]      ov_x;
    logic [2*WW-1:0] od_x;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bsp_output_port #(
        .N_IN(NL), .DATA_W(DW), .PORT_ID(ME), .DEPTH(4), .GRANTS(2),
        .EXTRA_OUTS(0), .HDR_MODE(HDR_STRIP)
    ) dut_i (
        .clk(clk), .rst(rst), .in_valid(vld), .in_word(wrd),
        .in_stall(stall_i), .out_valid(ov_i), .out_data(od_i)
    );

    bsp_output_port #(
        .N_IN(NL), .DATA_W(DW), .PORT_ID(ME), .DEPTH(4), .GRANTS(2),
        .EXTRA_OUTS(1), .HDR_MODE(HDR_KEEP)
    ) dut_x (
        .clk(clk), .rst(rst), .in_valid(vld), .in_word(wrd),
        .in_stall(stall_x), .out_valid(ov_x), .out_data(od_x)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic put_lane(input int l, input int h, input logic [DW-1:0] p);
        vld[l] = 1'b1;
        wrd[l*WW +: WW] = {6'(h), p};
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        vld = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        do_reset();
        check(ov_i == 1'b0, "R9 out_valid after reset", 64'(ov_i), 64'd0);
        check(ov_x == 2'b00, "R9 extra out_valid after reset", 64'(ov_x), 64'd0);
        check(stall_i == '0, "R9 stall idle", stall_i, 64'd0);
    endtask

    task automatic t_single;
        do_reset();
        put_lane(10, ME, 16'hABCD);
        #1 check(stall_i == '0, "R1 single lane not stalled", stall_i, 64'd0);
        @(posedge clk); #1;
        check(ov_i == 1'b1 && od_i == 16'hABCD, "R3 R7 single packet out",
              64'(od_i), 64'hABCD);
        @(negedge clk); vld = '0;
        @(posedge clk); #1;
        check(ov_i == 1'b0, "R3 no output when idle", 64'(ov_i), 64'd0);
        @(negedge clk);
    endtask

    task automatic t_nomatch;
        do_reset();
        put_lane(3, 6, 16'h0BAD);
        put_lane(20, 63, 16'h0BAE);
        #1 check(stall_i == '0, "R2 foreign lanes not stalled", stall_i, 64'd0);
        @(posedge clk); #1;
        check(ov_i == 1'b0, "R2 foreign packets ignored", 64'(ov_i), 64'd0);
        @(negedge clk);
        put_lane(30, ME, 16'h0030);
        @(posedge clk); #1;
        check(ov_i == 1'b1 && od_i == 16'h0030, "R2 mixed picks only own",
              64'(od_i), 64'h0030);
        @(negedge clk); vld = '0;
    endtask

    task automatic t_contend;
        do_reset();
        put_lane(1, ME, 16'h1001);
        put_lane(2, ME, 16'h1002);
        put_lane(3, ME, 16'h1003);
        #1 check(stall_i == 64'h8, "R4 R6 third lane stalled", stall_i, 64'h8);
        @(posedge clk); #1;
        check(ov_i == 1'b1 && od_i == 16'h1001, "R4 first in scan out",
              64'(od_i), 64'h1001);
        @(negedge clk); vld[1] = 1'b0; vld[2] = 1'b0;
        #1 check(stall_i == '0, "R6 held lane now taken", stall_i, 64'd0);
        @(posedge clk); #1;
        check(ov_i == 1'b1 && od_i == 16'h1002, "R5 buffered before newcomer",
              64'(od_i), 64'h1002);
        @(negedge clk); vld = '0;
        @(posedge clk); #1;
        check(ov_i == 1'b1 && od_i == 16'h1003, "R5 held lane last",
              64'(od_i), 64'h1003);
        @(posedge clk); #1;
        check(ov_i == 1'b0, "R6 buffer drained", 64'(ov_i), 64'd0);
        @(negedge clk);
    endtask

    task automatic t_wrap;
        do_reset();
        put_lane(40, ME, 16'h4040);
        put_lane(50, ME, 16'h4050);
        put_lane(60, ME, 16'h4060);
        #1 check(stall_i == (64'd1 << 60), "R4 lane 60 stalled", stall_i, 64'd1 << 60);
        @(posedge clk); #1;
        check(od_i == 16'h4040, "R4 lane 40 first", 64'(od_i), 64'h4040);
        @(negedge clk); vld[40] = 1'b0; vld[50] = 1'b0;
        put_lane(45, ME, 16'h4045);
        #1 check(stall_i == '0, "R4 both taken after pointer", stall_i, 64'd0);
        @(posedge clk); #1;
        check(od_i == 16'h4050, "R5 lane 50 from buffer", 64'(od_i), 64'h4050);
        @(negedge clk); vld = '0;
        @(posedge clk); #1;
        check(od_i == 16'h4060, "R4 lane 60 before wrap", 64'(od_i), 64'h4060);
        @(posedge clk); #1;
        check(ov_i == 1'b1 && od_i == 16'h4045, "R4 wrapped to lane 45",
              64'(od_i), 64'h4045);
        @(negedge clk);
    endtask

    task automatic t_full;
        logic [NL-1:0] pend;
        do_reset();
        for (int l = 0; l < 12; l++) put_lane(l, ME, 16'(16'h2000 + l));
        pend = vld;
        for (int c = 1; c <= 12; c++) begin
            vld = pend;
            #1;
            if (c == 5) check(stall_i == 64'hE00, "R6 stall when buffer full",
                              stall_i, 64'hE00);
            pend = pend & stall_i;
            @(posedge clk); #1;
            check(ov_i == 1'b1 && od_i == 16'(16'h2000 + c - 1),
                  "R5 R6 burst order kept", 64'(od_i), 64'(16'h2000 + c - 1));
            @(negedge clk);
        end
        vld = '0;
        @(posedge clk); #1;
        check(ov_i == 1'b0, "R6 nothing extra after burst", 64'(ov_i), 64'd0);
        @(negedge clk);
    endtask

    task automatic t_extra;
        do_reset();
        put_lane(7, ME, 16'h3007);
        put_lane(9, ME, 16'h3009);
        #1 check(stall_x == '0, "R8 two lanes fit two slots", stall_x, 64'd0);
        @(posedge clk); #1;
        check(ov_x == 2'b11, "R8 both slots valid", 64'(ov_x), 64'd3);
        check(od_x[WW-1:0] == {6'd5, 16'h3007}, "R7 R8 slot0 keeps header",
              64'(od_x[WW-1:0]), 64'({6'd5, 16'h3007}));
        check(od_x[2*WW-1:WW] == {6'd5, 16'h3009}, "R7 R8 slot1 keeps header",
              64'(od_x[2*WW-1:WW]), 64'({6'd5, 16'h3009}));
        @(negedge clk); vld = '0;
        @(posedge clk); #1;
        check(ov_x == 2'b00, "R8 no leftover", 64'(ov_x), 64'd0);
        check(ov_i == 1'b1 && od_i == 16'h3009, "R5 single slot serialises",
              64'(od_i), 64'h3009);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        t_reset();
        t_single();
        t_nomatch();
        t_contend();
        t_wrap();
        t_full();
        t_extra();
        summary();
    end
endmodule